// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Route Lookup

This block maps a 32-bit IPv4 destination address to an output interface number by longest-prefix match. The route table lives in an on-chip node memory organised as a binary trie. Node 0 is the root, which stands for the empty prefix. A lookup starts at the root and consumes the address one bit per step, starting at the most significant bit. At each node it records the port of the deepest node seen so far that carries a route. When the walk can go no further, the block returns the recorded port with a hit flag. If no node on the path carried a route, it returns a fixed default port with the hit flag clear.

A control processor fills the table one node per cycle through a write port. The lookup side takes an address on a valid/ready request channel and returns the port and hit flag on a valid/ready response channel. Only one lookup is in flight at a time. Table writes are held off while a lookup is in flight, so a walk always sees a consistent table.

Top module: `lpm_trie_lookup`

## Requirements
- R1: A node word is written to memory entry `wr_addr` on a rising edge where `wr_en` and `wr_ready` are both high. The node word has four fields, from MSB to LSB: the zero-branch child index (NODE_AW bits), the one-branch child index (NODE_AW bits), a route-present bit, and the route port (PORT_W bits).
- R2: The walk begins at node 0 and takes address bit 31 first. A 0 bit follows the zero-branch child and a 1 bit follows the one-branch child. A child index of 0 means no child and ends the walk.
- R3: When one or more nodes on the walked path have the route-present bit set, the response carries the port of the deepest such node, with `resp_hit`=1.
- R4: When no node on the walked path has the route-present bit set, the response carries `resp_hit`=0 and `resp_port`=DEFAULT_PORT (15 by default).
- R5: Let k be the number of nodes the walk reads. `resp_valid` rises on the k-th rising edge after the edge that accepted the request.
- R6: A node at depth ADDR_W (a full 32-bit route) ends the walk whatever its child fields hold. No walk reads more than ADDR_W+1 nodes.
- R7: From the edge that accepts a request until the response has been taken, `req_ready` stays low.
- R8: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_port` and `resp_hit` hold their values.
- R9: While a lookup is in flight, `wr_ready` is low and a pending write waits. When idle, a write takes priority: `req_ready` is low in any cycle in which `wr_en` is high.
- R10: After reset, `resp_valid`=0, and `req_ready` and `wr_ready` are high while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Node write request |
| wr_ready | output | 1 | Write accepted this cycle when high |
| wr_addr | input | NODE_AW | Node index to write |
| wr_data | input | 2*NODE_AW+PORT_W+1 | Node word {child0, child1, route bit, port} |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | ADDR_W | Destination address |
| resp_valid | output | 1 | Result valid |
| resp_ready | input | 1 | Result consumed when high |
| resp_port | output | PORT_W | Matched port, or the default port on a miss |
| resp_hit | output | 1 | A route matched |

## Verification
Each result is due a fixed number of cycles after the request: the number of trie nodes on the address's path. The bench works that number out from its own prefix list, as one plus the longest run of leading bits the address shares with any stored prefix, capped at the prefix length. The bench drives and samples on falling edges. It counts falling edges from the accepting edge and requires `resp_valid` to appear on exactly the (k+1)-th falling edge. Port and hit flag are compared in that same sample. Held responses, stalled writes and the idle write priority are checked on the falling edges between the relevant rising edges.

// File: rtl/lpm_trie_pkg.sv
package lpm_trie_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/trie_node_ram.sv
// Simple dual-port node store: one write port, one registered read port.
module trie_node_ram #(
  parameter int AW = 8,
  parameter int DW = 21
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/trie_walker.sv
// Walk controller: one node per cycle, tracks deepest route seen.
module trie_walker
  import lpm_trie_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          AW           = 8,
  parameter int          PW           = 4,
  parameter int unsigned DEFAULT_PORT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PW-1:0]     resp_port,
  output logic              resp_hit,
  input  logic              wr_en,
  output logic              wr_ready,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [2*AW+PW:0]  node
);
  localparam int              NODE_W = 2 * AW + PW + 1;
  localparam int              DEP_W  = $clog2(ADDR_W + 1);
  localparam logic [PW-1:0]   DEF_P  = PW'(DEFAULT_PORT);
  localparam logic [DEP_W-1:0] MAX_D = DEP_W'(ADDR_W);

  walk_state_e       state_q;
  logic [ADDR_W-1:0] addr_sh_q;
  logic [DEP_W-1:0]  depth_q;
  logic [PW-1:0]     best_port_q;
  logic              best_hit_q;

  // node field decode
  logic [AW-1:0] n_child0, n_child1, next_node;
  logic          n_route;
  logic [PW-1:0] n_port;
  assign n_child0 = node[NODE_W-1 -: AW];
  assign n_child1 = node[PW+AW -: AW];
  assign n_route  = node[PW];
  assign n_port   = node[PW-1:0];

  logic accept, last_step, cur_hit;
  logic [PW-1:0] cur_port;

  always_comb begin
    req_ready = (state_q == ST_IDLE) && !wr_en;
    wr_ready  = (state_q == ST_IDLE);
    accept    = req_ready && req_valid;
    cur_hit   = best_hit_q | n_route;
    cur_port  = n_route ? n_port : best_port_q;
    next_node = addr_sh_q[ADDR_W-1] ? n_child1 : n_child0;
    last_step = (depth_q == MAX_D) || (next_node == '0);
    rd_en     = accept || ((state_q == ST_WALK) && !last_step);
    rd_addr   = accept ? '0 : next_node;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_sh_q   <= '0;
      depth_q     <= '0;
      best_port_q <= DEF_P;
      best_hit_q  <= 1'b0;
      resp_valid  <= 1'b0;
      resp_port   <= DEF_P;
      resp_hit    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_sh_q   <= req_addr;
            depth_q     <= '0;
            best_port_q <= DEF_P;
            best_hit_q  <= 1'b0;
            state_q     <= ST_WALK;
          end
        end
        ST_WALK: begin
          best_hit_q  <= cur_hit;
          best_port_q <= cur_port;
          if (last_step) begin
            resp_valid <= 1'b1;
            resp_hit   <= cur_hit;
            resp_port  <= cur_hit ? cur_port : DEF_P;
            state_q    <= ST_DONE;
          end else begin
            addr_sh_q <= addr_sh_q << 1;
            depth_q   <= depth_q + 1'b1;
          end
        end
        ST_DONE: begin
          if (resp_ready) begin
            resp_valid <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpm_trie_lookup.sv
module lpm_trie_lookup #(
  parameter int          ADDR_W       = 32,
  parameter int          NODE_AW      = 8,
  parameter int          PORT_W       = 4,
  parameter int unsigned DEFAULT_PORT = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  output logic                      wr_ready,
  input  logic [NODE_AW-1:0]        wr_addr,
  input  logic [2*NODE_AW+PORT_W:0] wr_data,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      resp_valid,
  input  logic                      resp_ready,
  output logic [PORT_W-1:0]         resp_port,
  output logic                      resp_hit
);
  localparam int NODE_W = 2 * NODE_AW + PORT_W + 1;

  logic              rd_en;
  logic [NODE_AW-1:0] rd_addr;
  logic [NODE_W-1:0] rd_node;
  logic              ram_we;

  assign ram_we = wr_en && wr_ready;

  trie_node_ram #(.AW(NODE_AW), .DW(NODE_W)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_node)
  );

  trie_walker #(
    .ADDR_W(ADDR_W), .AW(NODE_AW), .PW(PORT_W), .DEFAULT_PORT(DEFAULT_PORT)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_port  (resp_port),
    .resp_hit   (resp_hit),
    .wr_en      (wr_en),
    .wr_ready   (wr_ready),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .node       (rd_node)
  );
endmodule

// File: rtl/lpm_trie_chk.sv
module lpm_trie_chk #(
  parameter int          ADDR_W       = 32,
  parameter int          PORT_W       = 4,
  parameter int unsigned DEFAULT_PORT = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [PORT_W-1:0] resp_port,
  input logic              resp_hit,
  input logic              wr_ready
);
  localparam int CNT_W = $clog2(ADDR_W + 2) + 1;
  localparam logic [CNT_W-1:0] MAX_NODES = CNT_W'(ADDR_W + 1);

  logic             inflight;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= 1'b0;
      cnt      <= '0;
    end else if (req_valid && req_ready) begin
      inflight <= 1'b1;
      cnt      <= '0;
    end else if (inflight && resp_valid) begin
      inflight <= 1'b0;
    end else if (inflight) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_port) && $stable(resp_hit));

  assert_miss_default_R4: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_hit |-> resp_port == PORT_W'(DEFAULT_PORT));

  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready && !wr_ready);

  assert_write_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !wr_ready && !req_ready);

  assert_walk_bound_R6: assert property (@(posedge clk) disable iff (rst)
    inflight |-> cnt <= MAX_NODES);
endmodule

bind lpm_trie_lookup lpm_trie_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DEFAULT_PORT(DEFAULT_PORT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_port(resp_port),
  .resp_hit(resp_hit), .wr_ready(wr_ready)
);

// File: tb/sim_lpm_trie_lookup.sv
`timescale 1ns/1ps
module sim_lpm_trie_lookup;
  localparam int NN = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [20:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [3:0]  resp_port;
  logic        resp_hit;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  lpm_trie_lookup u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_port(resp_port), .resp_hit(resp_hit)
  );

  // bench prefix list and bench-built trie
  logic [31:0] pv [64];
  int          pl [64];
  int          pp [64];
  int          np;
  logic [7:0]  c0 [NN];
  logic [7:0]  c1 [NN];
  bit          rv [NN];
  logic [3:0]  rp [NN];
  int          used;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int common_bits(input logic [31:0] a, input logic [31:0] b);
    for (int i = 31; i >= 0; i--) if (a[i] != b[i]) return 31 - i;
    return 32;
  endfunction

  task automatic expect_of(input logic [31:0] a, output bit h, output int port, output int k);
    int best;
    int deep;
    best = -1; deep = 0; h = 0; port = 15;
    for (int i = 0; i < np; i++) begin
      int m;
      m = common_bits(a, pv[i]);
      if (m >= pl[i] && pl[i] >= best) begin best = pl[i]; port = pp[i]; h = 1; end
      deep = (m < pl[i]) ? ((m > deep) ? m : deep) : ((pl[i] > deep) ? pl[i] : deep);
    end
    k = deep + 1;
  endtask

  task automatic clear_table();
    np = 0; used = 1;
    for (int i = 0; i < NN; i++) begin c0[i] = '0; c1[i] = '0; rv[i] = 0; rp[i] = '0; end
  endtask

  task automatic add_pfx(input logic [31:0] val, input int len, input int port);
    int n;
    pv[np] = val; pl[np] = len; pp[np] = port; np++;
    n = 0;
    for (int d = 0; d < len; d++) begin
      if (val[31-d]) begin
        if (c1[n] == 0) begin c1[n] = 8'(used); used++; end
        n = int'(c1[n]);
      end else begin
        if (c0[n] == 0) begin c0[n] = 8'(used); used++; end
        n = int'(c0[n]);
      end
    end
    rv[n] = 1; rp[n] = 4'(port);
  endtask

  task automatic load_table();
    for (int i = 0; i < NN; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 8'(i); wr_data = {c0[i], c1[i], rv[i], rp[i]};
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  // one lookup; hold>0 keeps resp_ready low for that many samples
  task automatic lookup(input logic [31:0] a, input string rq, input int hold);
    bit eh; int ep; int ek; int lat; logic [3:0] held;
    expect_of(a, eh, ep, ek);
    @(negedge clk);
    resp_ready = (hold == 0);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    #1 req_valid = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!resp_valid && lat < 60);
    chk(rq, "hit", int'(resp_hit), int'(eh));
    chk(rq, "port", int'(resp_port), ep);
    chk("R5", "latency", lat, ek + 1);
    if (hold > 0) begin
      held = resp_port;
      repeat (hold) @(negedge clk);
      chk("R8", "held valid", int'(resp_valid), 1);
      chk("R8", "held port", int'(resp_port), int'(held));
      chk("R7", "ready low while held", int'(req_ready), 0);
      resp_ready = 1;
      @(negedge clk);
      chk("R8", "valid drops after take", int'(resp_valid), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk("R10", "resp_valid after reset", int'(resp_valid), 0);
    chk("R10", "req_ready after reset", int'(req_ready), 1);
    chk("R10", "wr_ready after reset", int'(wr_ready), 1);

    // empty table: root only, miss
    clear_table(); load_table();
    lookup(32'h1234_5678, "R4", 0);

    // five-bit example table in the top address bits (R1, R2, R3)
    clear_table();
    add_pfx(32'b001 << 29, 3, 2);
    add_pfx(32'b0100 << 28, 4, 3);
    add_pfx(32'b10 << 30, 2, 1);
    add_pfx(32'b01100 << 27, 5, 5);
    load_table();
    lookup(32'b01100 << 27, "R3", 0);
    lookup(32'b01001 << 27, "R3", 0);
    lookup(32'b00111 << 27, "R2", 0);
    lookup(32'b10111 << 27, "R3", 0);
    lookup(32'b11000 << 27, "R4", 0);
    lookup(32'b01101 << 27, "R1", 3);

    // write stalled by an in-flight lookup (R9)
    begin
      int lat;
      @(negedge clk);
      req_valid = 1; req_addr = 32'b01100 << 27;
      @(posedge clk);
      #1 req_valid = 0;
      wr_en = 1; wr_addr = 8'd0; wr_data = '0;
      lat = 0;
      do begin
        @(negedge clk); lat++;
        if (!resp_valid) chk("R9", "wr_ready during walk", int'(wr_ready), 0);
      end while (!resp_valid && lat < 60);
      chk("R9", "result unaffected port", int'(resp_port), 5);
      chk("R9", "wr_ready with result", int'(wr_ready), 0);
      @(negedge clk);
      chk("R9", "idle write accepted", int'(wr_ready), 1);
      chk("R9", "req_ready low under write", int'(req_ready), 0);
      @(posedge clk);
      #1 wr_en = 0;
      np = 0;  // root cleared: every address misses
      lookup(32'b01100 << 27, "R9", 0);
    end

    // dotted-quad table, host route and catch-all (R3, R4, R6)
    clear_table();
    add_pfx({8'd12, 8'd82, 16'd0}, 16, 3);
    add_pfx({8'd12, 8'd82, 8'd100, 8'd0}, 24, 2);
    add_pfx({8'd128, 8'd16, 8'd120, 8'd0}, 24, 1);
    load_table();
    lookup({8'd12, 8'd82, 8'd100, 8'd101}, "R3", 0);
    lookup({8'd12, 8'd82, 8'd7, 8'd7}, "R3", 0);
    lookup({8'd128, 8'd16, 8'd121, 8'd1}, "R4", 0);
    add_pfx({8'd10, 8'd0, 8'd0, 8'd1}, 32, 7);
    add_pfx(32'h0, 0, 9);
    load_table();
    lookup({8'd10, 8'd0, 8'd0, 8'd1}, "R6", 0);
    lookup({8'd10, 8'd0, 8'd0, 8'd0}, "R6", 0);
    lookup({8'd1, 8'd2, 8'd3, 8'd4}, "R3", 0);

    // random tables
    for (int r = 0; r < 5; r++) begin
      clear_table();
      for (int i = 0; i < 6; i++)
        add_pfx($urandom, int'($urandom_range(0, 32)), int'($urandom_range(0, 14)));
      load_table();
      for (int j = 0; j < 40; j++) begin
        logic [31:0] a;
        logic [31:0] mask;
        int sel;
        a = $urandom;
        if ($urandom_range(0, 1) == 1) begin
          sel = int'($urandom_range(0, np - 1));
          mask = (pl[sel] == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - pl[sel]));
          a = (pv[sel] & mask) | (a & ~mask);
        end
        lookup(a, "R3", (j % 13 == 5) ? 2 : 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule